// File: doc/BRIEF.md
# Nonvolatile SRAM Unlock Sequence Detector

This block sits beside the read path of a memory that backs its SRAM with nonvolatile cells. It watches every accepted chip-enable read cycle and looks for a fixed run of six addresses. The first five addresses are common to both commands. The sixth address chooses between copying the SRAM into the nonvolatile cells (store) and copying the nonvolatile contents back into the SRAM (recall). A write cycle, or a read of any other address, breaks the run.

When a run completes, the block pulses a start signal for the chosen operation. It also raises a busy flag for a duration that is set separately for each operation. While busy, the data-output enable is dropped so that the data bus floats. Read strobes that arrive during this window are ignored. Both durations are counted in clock cycles. The output-enable pin of the memory plays no part in starting an operation.

Top module: `nvs_seq_detect`

## Requirements
- R1: Six consecutive accepted reads whose low 14 address bits are 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0 produce a store_start pulse.
- R2: The same five leading addresses followed by 0x0C63 produce a recall_start pulse.
- R3: Only address bits [13:0] are compared. Setting any higher address bit at any step neither breaks nor changes the sequence.
- R4: An accepted strobe with we_n low (a write) at any step returns the matcher to idle, even when its address is the expected one.
- R5: A read whose address is not the next expected one returns the matcher to idle. If that address is 0x0E38, the matcher resumes with one step matched. A sixth address other than the two command codes starts nothing.
- R6: store_start and recall_start are single-clock pulses, high in the cycle after the sixth read is sampled, and never high together. busy rises on the same clock edge.
- R7: busy stays high for exactly STORE_CYC clock cycles after a store and RECALL_CYC clock cycles after a recall.
- R8: Read strobes sampled while busy is high are ignored and advance no sequence.
- R9: dout_en is low whenever busy is high and high otherwise.
- R10: After reset store_start, recall_start and busy are low, dout_en is high, and the matcher is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | One clock per chip-enable cycle; the address is sampled with it |
| we_n | input | 1 | Write enable, active low; low during a strobe marks a write |
| addr | input | ADDR_W | Address bus sampled with rd_strobe |
| store_start | output | 1 | One-cycle pulse starting a store |
| recall_start | output | 1 | One-cycle pulse starting a recall |
| busy | output | 1 | High while a nonvolatile operation runs |
| dout_en | output | 1 | Data output enable; low forces high impedance |

## Verification
If the step register holds a wrong value, the fault shows up at the ports in one of two ways. A start pulse appears one cycle after a read that should not have completed the run, or a correct run ends with no pulse. Either way it is visible within one cycle of the sixth read. The sweeps insert a bad address, a write, a repeat of the first code or a high address bit at each of the six positions, so a matcher that advances, resets or restarts wrongly at any step changes the pulse count. A wrong busy counter changes the busy length measured cycle by cycle. It also lets reads inside the window advance the sequence, and a later single final code then triggers an operation.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  // Width of the compared address slice and length of the unlock run.
  localparam int CODE_W  = 14;
  localparam int SEQ_LEN = 6;
  localparam int PRE_LEN = SEQ_LEN - 1;
  // Prefix codes plus two final codes.
  localparam int NCODES  = PRE_LEN + 2;
  localparam int STEP_W  = $clog2(SEQ_LEN);

  // Index of each final code inside the hit vector.
  localparam int IDX_STORE  = PRE_LEN;
  localparam int IDX_RECALL = PRE_LEN + 1;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } nv_op_e;

  // Code table, ordered: five prefix steps, then store, then recall.
  function automatic logic [CODE_W-1:0] code_at(input int idx);
    logic [CODE_W-1:0] c;
    case (idx)
      0:       c = 14'h0E38;
      1:       c = 14'h31C7;
      2:       c = 14'h03E0;
      3:       c = 14'h3C1F;
      4:       c = 14'h303F;
      5:       c = 14'h0FC0;
      default: c = 14'h0C63;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/nvs_code_match.sv
module nvs_code_match
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCODES-1:0] hit
);

  logic [CODE_W-1:0] addr_low;

  // Upper address bits do not take part in the decode.
  assign addr_low = addr[CODE_W-1:0];

  for (genvar g = 0; g < NCODES; g++) begin : g_cmp
    assign hit[g] = (addr_low == code_at(g));
  end

endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm
  import nvs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_write,
  input  logic [NCODES-1:0] hit,
  output logic              go_store,
  output logic              go_recall,
  output logic              store_start,
  output logic              recall_start
);

  logic [STEP_W-1:0] step_q, step_d;
  logic              step_en;
  nv_op_e            op_d;
  logic              st_q, rc_q;

  // Number of steps matched so far (0 means idle).
  always_comb begin
    step_d = '0;
    op_d   = OP_NONE;
    if (is_write) begin
      step_d = '0;
    end else if (step_q < STEP_W'(PRE_LEN) && hit[step_q]) begin
      step_d = step_q + STEP_W'(1);
    end else if (step_q == STEP_W'(PRE_LEN) && hit[IDX_STORE]) begin
      op_d = OP_STORE;
    end else if (step_q == STEP_W'(PRE_LEN) && hit[IDX_RECALL]) begin
      op_d = OP_RECALL;
    end else if (hit[0]) begin
      step_d = STEP_W'(1);
    end
  end

  assign step_en   = accept;
  assign go_store  = accept && (op_d == OP_STORE);
  assign go_recall = accept && (op_d == OP_RECALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (step_en) begin
      step_q <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b0;
      rc_q <= 1'b0;
    end else begin
      st_q <= go_store;
      rc_q <= go_recall;
    end
  end

  assign store_start  = st_q;
  assign recall_start = rc_q;

endmodule

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
  parameter int STORE_CYC  = 1000,
  parameter int RECALL_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_store,
  input  logic go_recall,
  output logic busy
);

  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] ST_LOAD = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RECALL_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (go_store) begin
      cnt_d  = ST_LOAD;
      busy_d = 1'b1;
    end else if (go_recall) begin
      cnt_d  = RC_LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_en = go_store || go_recall || busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int STORE_CYC  = 1000,
  parameter int RECALL_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              store_start,
  output logic              recall_start,
  output logic              busy,
  output logic              dout_en
);

  logic [NCODES-1:0] hit;
  logic              accept;
  logic              go_store, go_recall;

  // Strobes seen during a nonvolatile operation are dropped.
  assign accept = rd_strobe && !busy;

  nvs_code_match #(
    .ADDR_W(ADDR_W)
  ) u_match (
    .addr(addr),
    .hit (hit)
  );

  nvs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .is_write    (!we_n),
    .hit         (hit),
    .go_store    (go_store),
    .go_recall   (go_recall),
    .store_start (store_start),
    .recall_start(recall_start)
  );

  nvs_busy_timer #(
    .STORE_CYC (STORE_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_store (go_store),
    .go_recall(go_recall),
    .busy     (busy)
  );

  assign dout_en = !busy;

endmodule

// File: rtl/nvs_seq_detect_chk.sv
module nvs_seq_detect_chk #(
  parameter int ADDR_W     = 15,
  parameter int STORE_CYC  = 1000,
  parameter int RECALL_CYC = 2000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              store_start,
  input logic              recall_start,
  input logic              busy,
  input logic              dout_en
);

  logic [31:0] len_q;
  logic        was_store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q       <= '0;
      was_store_q <= 1'b0;
    end else if (store_start || recall_start) begin
      len_q       <= 32'd1;
      was_store_q <= store_start;
    end else if (busy) begin
      len_q <= len_q + 32'd1;
    end
  end

  // R6
  store_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);
  // R6
  recall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |=> !recall_start);
  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_start && recall_start));
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |-> (busy && !$past(busy)));
  // R1
  store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> ($past(rd_strobe) && $past(addr[13:0]) == 14'h0FC0));
  // R2
  recall_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_start |-> ($past(rd_strobe) && $past(addr[13:0]) == 14'h0C63));
  // R4
  no_write_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_start || recall_start) |-> $past(we_n));
  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !(store_start || recall_start));
  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == (was_store_q ? 32'(STORE_CYC) : 32'(RECALL_CYC))));

endmodule

bind nvs_seq_detect nvs_seq_detect_chk #(
  .ADDR_W    (ADDR_W),
  .STORE_CYC (STORE_CYC),
  .RECALL_CYC(RECALL_CYC)
) u_chk (.*);

// File: tb/nvs_seq_detect_bench.sv
module nvs_seq_detect_bench;

  localparam int AW = 15;
  localparam int SC = 7;
  localparam int RC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_strobe = 1'b0;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          store_start, recall_start, busy, dout_en;

  int checks = 0;
  int errors = 0;
  int n_store = 0;
  int n_recall = 0;

  always #2.5 clk = ~clk;

  nvs_seq_detect #(
    .ADDR_W(AW), .STORE_CYC(SC), .RECALL_CYC(RC)
  ) u_nvs_seq_detect (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .we_n(we_n), .addr(addr),
    .store_start(store_start), .recall_start(recall_start),
    .busy(busy), .dout_en(dout_en)
  );

  always @(posedge clk) begin
    if (store_start)  n_store++;
    if (recall_start) n_recall++;
  end

  function automatic logic [AW-1:0] code(input int i);
    case (i)
      0: return 15'h0E38;
      1: return 15'h31C7;
      2: return 15'h03E0;
      3: return 15'h3C1F;
      4: return 15'h303F;
      5: return 15'h0FC0;
      default: return 15'h0C63;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; strobe is sampled on the next rising edge.
  task automatic rd(input logic [AW-1:0] a, input logic w);
    rd_strobe = 1'b1;
    addr      = a;
    we_n      = w;
    @(negedge clk);
    rd_strobe = 1'b0;
    we_n      = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic full_and_measure(input bit is_store);
    int len;
    for (int i = 0; i < 5; i++) rd(code(i), 1'b1);
    rd(is_store ? code(5) : code(6), 1'b1);
    check(is_store ? "R1 store pulse" : "R2 recall pulse",
          is_store ? int'(store_start) : int'(recall_start), 1);
    check("R6 other pulse low", is_store ? int'(recall_start) : int'(store_start), 0);
    check("R6 busy rises with pulse", int'(busy), 1);
    check("R9 dout_en low while busy", int'(dout_en), 0);
    len = 1;
    @(negedge clk);
    check("R6 pulse one cycle", int'(store_start | recall_start), 0);
    while (busy) begin
      len++;
      @(negedge clk);
    end
    check("R7 busy length", len, is_store ? SC : RC);
    check("R9 dout_en back high", int'(dout_en), 1);
  endtask

  initial begin
    int s0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 store_start reset", int'(store_start), 0);
    check("R10 recall_start reset", int'(recall_start), 0);
    check("R10 busy reset", int'(busy), 0);
    check("R10 dout_en reset", int'(dout_en), 1);
    // R10: idle matcher; a lone final code starts nothing
    s0 = n_store;
    rd(code(5), 1'b1);
    wait_idle();
    check("R10 idle after reset", n_store - s0, 0);

    full_and_measure(1'b1);
    full_and_measure(1'b0);

    // R3: high address bit at each position, alternating operations
    for (int p = 0; p < 6; p++) begin
      s0 = n_store; r0 = n_recall;
      for (int i = 0; i < 6; i++) begin
        logic [AW-1:0] a;
        a = (i < 5) ? code(i) : code(5 + (p % 2));
        if (i == p) a[AW-1] = 1'b1;
        rd(a, 1'b1);
      end
      wait_idle();
      check("R3 high bit ignored", (p % 2 == 0) ? n_store - s0 : n_recall - r0, 1);
    end

    // R5: wrong address at each step breaks the run; a clean run then fires once
    for (int p = 0; p < 6; p++) begin
      s0 = n_store;
      for (int i = 0; i < p; i++) rd(code(i), 1'b1);
      rd(15'h1234, 1'b1);
      for (int i = p + 1; i < 6; i++) rd(code(i), 1'b1);
      wait_idle();
      check("R5 mismatch breaks run", n_store - s0, 0);
    end
    s0 = n_store;
    for (int i = 0; i < 6; i++) rd(code(i), 1'b1);
    wait_idle();
    check("R5 clean run after mismatches", n_store - s0, 1);

    // R5: a wrong sixth code starts nothing
    s0 = n_store; r0 = n_recall;
    for (int i = 0; i < 5; i++) rd(code(i), 1'b1);
    rd(15'h0FC1, 1'b1);
    wait_idle();
    check("R5 bad sixth code", (n_store - s0) + (n_recall - r0), 0);

    // R5: first code out of place restarts at one step
    for (int p = 1; p < 6; p++) begin
      r0 = n_recall;
      for (int i = 0; i < p; i++) rd(code(i), 1'b1);
      for (int i = 0; i < 5; i++) rd(code(i), 1'b1);
      rd(code(6), 1'b1);
      wait_idle();
      check("R5 restart on first code", n_recall - r0, 1);
    end

    // R4: a write of the expected address at each step aborts
    for (int p = 0; p < 6; p++) begin
      s0 = n_store;
      for (int i = 0; i < p; i++) rd(code(i), 1'b1);
      rd(code(p), 1'b0);
      for (int i = p + 1; i < 6; i++) rd(code(i), 1'b1);
      wait_idle();
      check("R4 write aborts", n_store - s0, 0);
    end

    // R8: reads during busy do not advance
    s0 = n_store;
    for (int i = 0; i < 6; i++) rd(code(i), 1'b1);
    for (int i = 0; i < 5; i++) rd(code(i), 1'b1);
    check("R9 dout_en low during busy reads", int'(dout_en), 0);
    wait_idle();
    rd(code(5), 1'b1);
    wait_idle();
    check("R8 busy reads ignored", n_store - s0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule